// File: doc/BRIEF.md
# Best-Match Associative Word Search

This block keeps a small table of binary words in flip-flops and, when asked, finds the entry that agrees with a presented sample in the greatest number of bit positions. Every loaded entry is compared with the sample at the same time. The per-bit equality result is the XNOR of the two bits, and the number of equal bits is the entry's score.

The winner is not chosen by a tree of magnitude comparators. A single shared threshold, the ramp, starts at the word width and falls by one each clock. An entry fires when its score equals the current ramp level. The first entry to fire latches itself and blocks every other entry, so the search stops as soon as the best score is reached. If several entries fire in the same cycle, the lowest index wins.

A search begins with a start strobe. The start edge captures the sample and clears the previous result. This is the initial phase. The sweep follows and is the latch phase. The block gives a one-cycle done pulse, a one-hot winner vector, a binary winner index and a found flag. The result outputs hold their values until the next accepted start.

Top module: `bestmatch_cam`

## Requirements
- R1: After reset, `done`, `win_found`, `win_onehot` and `win_idx` are all 0.
- R2: The score of a row is the number of bit positions in which the row equals the sample (the popcount of their XNOR). The winner is a loaded row that has the highest score.
- R3: When two or more loaded rows share the highest score, the row with the lowest index wins.
- R4: `done` is high for exactly one cycle. When the best score is S, `done` rises WIDTH-S+1 clock edges after the edge that accepted `start`. The worst case is WIDTH+1 edges, or WIDTH+2 cycles including the start cycle.
- R5: When a winner is found, `win_found` is 1, `win_onehot` has exactly one bit set, and that bit is at position `win_idx`. At all other times `win_onehot` has at most one bit set.
- R6: Only rows written since reset take part in a search. If no row has been written, the search ends on the first sweep edge with `done`=1, `win_found`=0 and `win_onehot`=0.
- R7: When `abort` is high during a sweep cycle, the search ends on that edge with `done`=1 and `win_found`=0. No row is latched.
- R8: A write presented while a search is in progress is dropped. The stored row keeps its old contents.
- R9: A `start` during a search is ignored. The result outputs keep their values until the next accepted `start`, which clears them to 0 at its edge.
- R10: The sample is captured on the edge that accepts `start`. Later changes on `sample` do not affect that search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the row table |
| wr_addr | input | IDXW | Row to write |
| wr_data | input | WIDTH | Word to store |
| sample | input | WIDTH | Word to search for |
| start | input | 1 | Begin a search (taken when idle) |
| abort | input | 1 | Stop the running search with no winner |
| win_onehot | output | ROWS | One-hot winning row |
| win_idx | output | IDXW | Binary index of the winning row |
| win_found | output | 1 | A winner was latched |
| done | output | 1 | One-cycle pulse when a search ends |

## Verification
The hardest case to reach from the ports is a search that is disturbed partway through. In such a search a write, a change of sample and a second start all land inside the sweep. The disturbance has to arrive while the ramp is still well above the best score. To set this up, the stimulus loads rows whose best score against the sample is low, which makes the sweep long. It then applies all three disturbances on the first sweep cycle. A later search for the word that the dropped write tried to store shows whether the table really stayed unchanged. Ties are created by loading the same word into two rows, and a second table state compares a zero-score winner against the empty case.

// File: rtl/bm_pkg.sv
package bm_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SWEEP = 1'b1
    } bm_state_e;
endpackage

// File: rtl/bm_store.sv
module bm_store #(
    parameter int ROWS  = 8,
    parameter int WIDTH = 16,
    localparam int IDXW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDXW-1:0]             wr_addr,
    input  logic [WIDTH-1:0]            wr_data,
    input  logic                        lock,
    output logic [ROWS-1:0][WIDTH-1:0]  row_data,
    output logic [ROWS-1:0]             row_vld
);
    typedef struct packed {
        logic [ROWS-1:0][WIDTH-1:0] data;
        logic [ROWS-1:0]            vld;
    } store_t;

    store_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en && !lock) begin
            for (int r = 0; r < ROWS; r++) begin
                if (wr_addr == IDXW'(r)) begin
                    s_d.data[r] = wr_data;
                    s_d.vld[r]  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign row_data = s_q.data;
    assign row_vld  = s_q.vld;
endmodule

// File: rtl/bm_scorer.sv
module bm_scorer #(
    parameter int ROWS  = 8,
    parameter int WIDTH = 16,
    localparam int SW   = $clog2(WIDTH + 1)
) (
    input  logic [ROWS-1:0][WIDTH-1:0] row_data,
    input  logic [WIDTH-1:0]           smp,
    output logic [ROWS-1:0][SW-1:0]    score
);
    for (genvar g = 0; g < ROWS; g++) begin : g_row
        logic [WIDTH-1:0] agree;
        assign agree = ~(row_data[g] ^ smp);
        always_comb begin
            score[g] = '0;
            for (int b = 0; b < WIDTH; b++) begin
                score[g] = score[g] + SW'(agree[b]);
            end
        end
    end
endmodule

// File: rtl/bm_race.sv
module bm_race
    import bm_pkg::*;
#(
    parameter int ROWS  = 8,
    parameter int WIDTH = 16,
    localparam int SW   = $clog2(WIDTH + 1),
    localparam int IDXW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     abort,
    input  logic [WIDTH-1:0]         sample,
    input  logic [ROWS-1:0]          row_vld,
    input  logic [ROWS-1:0][SW-1:0]  score,
    output logic [WIDTH-1:0]         smp_q,
    output logic                     busy,
    output logic [ROWS-1:0]          win_onehot,
    output logic [IDXW-1:0]          win_idx,
    output logic                     win_found,
    output logic                     done
);
    typedef struct packed {
        bm_state_e        st;
        logic [SW-1:0]    ramp;
        logic [WIDTH-1:0] smp;
        logic [ROWS-1:0]  oh;
        logic [IDXW-1:0]  idx;
        logic             found;
        logic             done;
    } race_t;

    race_t r_d, r_q;
    logic [ROWS-1:0] fire;
    logic [IDXW-1:0] pick;

    for (genvar g = 0; g < ROWS; g++) begin : g_fire
        assign fire[g] = row_vld[g] && (score[g] == r_q.ramp);
    end

    always_comb begin
        pick = '0;
        for (int r = ROWS - 1; r >= 0; r--) begin
            if (fire[r]) pick = IDXW'(r);
        end
    end

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st    = ST_SWEEP;
                    r_d.ramp  = SW'(WIDTH);
                    r_d.smp   = sample;
                    r_d.oh    = '0;
                    r_d.idx   = '0;
                    r_d.found = 1'b0;
                end
            end
            ST_SWEEP: begin
                if (abort || (row_vld == '0)) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else if (fire != '0) begin
                    r_d.st    = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.found = 1'b1;
                    r_d.idx   = pick;
                    r_d.oh    = ROWS'(1) << pick;
                end else if (r_q.ramp == '0) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else begin
                    r_d.ramp = r_q.ramp - SW'(1);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign smp_q      = r_q.smp;
    assign busy       = (r_q.st == ST_SWEEP);
    assign win_onehot = r_q.oh;
    assign win_idx    = r_q.idx;
    assign win_found  = r_q.found;
    assign done       = r_q.done;
endmodule

// File: rtl/bestmatch_cam.sv
module bestmatch_cam #(
    parameter int ROWS  = 8,
    parameter int WIDTH = 16,
    localparam int SW   = $clog2(WIDTH + 1),
    localparam int IDXW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDXW-1:0]  wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] sample,
    input  logic             start,
    input  logic             abort,
    output logic [ROWS-1:0]  win_onehot,
    output logic [IDXW-1:0]  win_idx,
    output logic             win_found,
    output logic             done
);
    logic [ROWS-1:0][WIDTH-1:0] row_data;
    logic [ROWS-1:0]            row_vld;
    logic [ROWS-1:0][SW-1:0]    score;
    logic [WIDTH-1:0]           smp_q;
    logic                       busy;

    bm_store #(.ROWS(ROWS), .WIDTH(WIDTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .lock     (busy),
        .row_data (row_data),
        .row_vld  (row_vld)
    );

    bm_scorer #(.ROWS(ROWS), .WIDTH(WIDTH)) u_scorer (
        .row_data (row_data),
        .smp      (smp_q),
        .score    (score)
    );

    bm_race #(.ROWS(ROWS), .WIDTH(WIDTH)) u_race (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .abort      (abort),
        .sample     (sample),
        .row_vld    (row_vld),
        .score      (score),
        .smp_q      (smp_q),
        .busy       (busy),
        .win_onehot (win_onehot),
        .win_idx    (win_idx),
        .win_found  (win_found),
        .done       (done)
    );
endmodule

// File: rtl/bm_checker.sv
module bm_checker #(
    parameter int ROWS  = 8,
    parameter int WIDTH = 16,
    localparam int IDXW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       start,
    input logic                       abort,
    input logic                       busy,
    input logic [ROWS-1:0][WIDTH-1:0] row_data,
    input logic [ROWS-1:0]            win_onehot,
    input logic [IDXW-1:0]            win_idx,
    input logic                       win_found,
    input logic                       done
);
    AST_ONEHOT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_onehot)); // R5
    AST_FOUND_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        win_found |-> ($countones(win_onehot) == 1)); // R5
    AST_IDX_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        win_found |-> win_onehot[win_idx]); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R4
    AST_ABORT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && abort) |=> (done && !win_found)); // R7
    AST_TABLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(row_data)); // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !$past(start)) |-> $stable(win_onehot)); // R9
endmodule

bind bestmatch_cam bm_checker #(.ROWS(ROWS), .WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .abort      (abort),
    .busy       (busy),
    .row_data   (row_data),
    .win_onehot (win_onehot),
    .win_idx    (win_idx),
    .win_found  (win_found),
    .done       (done)
);

// File: tb/bestmatch_cam_tb.sv
module bestmatch_cam_tb;
    localparam int ROWS  = 8;
    localparam int WIDTH = 16;
    localparam int IDXW  = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [IDXW-1:0]  wr_addr = '0;
    logic [WIDTH-1:0] wr_data = '0;
    logic [WIDTH-1:0] sample = '0;
    logic             start = 1'b0;
    logic             abort = 1'b0;
    logic [ROWS-1:0]  win_onehot;
    logic [IDXW-1:0]  win_idx;
    logic             win_found;
    logic             done;

    always #2.5 clk = ~clk;

    bestmatch_cam #(.ROWS(ROWS), .WIDTH(WIDTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sample(sample), .start(start), .abort(abort),
        .win_onehot(win_onehot), .win_idx(win_idx), .win_found(win_found),
        .done(done)
    );

    typedef struct {
        logic [ROWS-1:0] oh;
        int              idx;
        bit              found;
        longint          cyc;
        string           tag;
    } exp_t;

    exp_t             sb_q[$];
    exp_t             last;
    logic [WIDTH-1:0] shadow [ROWS];
    bit               loaded [ROWS];
    longint           cyc = 0;
    int               total = 0;
    int               bad = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string what, input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
        end
    endtask

    // monitor: pops expected results as done pulses appear
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R4 unexpected done", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                last = e;
                check(cyc == e.cyc, {e.tag, " R4 done cycle"}, cyc, e.cyc);
                check(win_found == e.found, {e.tag, " R6 found flag"}, win_found, e.found);
                check(win_onehot == e.oh, {e.tag, " R5 onehot"}, win_onehot, e.oh);
                if (e.found)
                    check(int'(win_idx) == e.idx, {e.tag, " R2 winner index"}, win_idx, e.idx);
            end
        end
    end

    task automatic write_row(input int a, input logic [WIDTH-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = IDXW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        shadow[a] = d; loaded[a] = 1'b1;
    endtask

    // mode 0: plain, 1: abort on first sweep cycle, 2: disturb on first sweep cycle
    task automatic search(input logic [WIDTH-1:0] s, input int mode, input string tag);
        exp_t   e;
        int     best;
        longint c0;
        @(negedge clk);
        sample = s; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        c0 = cyc;
        check(win_found == 1'b0 && win_onehot == '0, "R9 start clears result", win_onehot, 0);
        best = -1; e.idx = 0; e.oh = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (loaded[r]) begin
                int sc;
                sc = $countones(~(shadow[r] ^ s));
                if (sc > best) begin best = sc; e.idx = r; end
            end
        end
        e.tag = tag;
        if (mode == 1 || best < 0) begin
            e.found = 1'b0; e.cyc = c0 + 1;
        end else begin
            e.found = 1'b1; e.oh = ROWS'(1) << e.idx;
            e.cyc = c0 + longint'(WIDTH - best + 1);
        end
        sb_q.push_back(e);
        if (mode == 1) begin
            abort = 1'b1;
            @(negedge clk);
            abort = 1'b0;
        end else if (mode == 2) begin
            wr_en = 1'b1; wr_addr = '0; wr_data = ~shadow[0];
            sample = ~s; start = 1'b1;
            @(negedge clk);
            wr_en = 1'b0; start = 1'b0;
        end
        while (sb_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(win_onehot == last.oh && win_found == last.found, "R9 result held", win_onehot, last.oh);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int r = 0; r < ROWS; r++) begin shadow[r] = '0; loaded[r] = 1'b0; end
        repeat (3) @(negedge clk);
        check(done == 0 && win_found == 0 && win_onehot == '0 && win_idx == '0,
              "R1 reset outputs", win_onehot, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R6: empty table
        search(16'h0000, 0, "R6 empty");
        // R6: only loaded rows compete (unloaded rows hold zero)
        write_row(2, 16'h000F);
        write_row(5, 16'h0001);
        search(16'h0000, 0, "R6 partial");
        // fill table
        for (int r = 0; r < ROWS; r++) write_row(r, 16'(r * 16'h1357) ^ 16'hA5C3);
        write_row(6, shadow[1]);
        // exact match, shortest sweep
        search(shadow[3], 0, "R2 exact");
        // R3: tie between rows 1 and 6
        search(shadow[1], 0, "R3 tie");
        // R2: assorted samples
        for (int i = 0; i < 8; i++) search(16'($urandom), 0, "R2 pattern");
        // R7: abort
        search(shadow[4], 1, "R7 abort");
        // R8/R9/R10: disturbed long sweep, then look for the dropped word
        write_row(0, 16'h0000);
        for (int r = 1; r < ROWS; r++) write_row(r, 16'hFF00);
        search(16'hFFFF, 2, "R10 disturbed");
        search(16'hFFFF, 0, "R8 write dropped");
        // R2: a zero-score winner
        for (int r = 0; r < ROWS; r++) write_row(r, 16'hFFFF);
        search(16'h0000, 0, "R4 worst case");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule